// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block turns one data-memory access into a region select and a local index. An access arrives either as a 5-bit bank number with a 7-bit direct offset, or as a 16-bit pointer. Both forms reduce to a 12-bit data address: the top five bits pick one of 32 banks and the low seven bits pick a byte inside that bank. The offset inside the bank then selects one of four regions. The core registers and the shared common RAM appear at the same offsets in every bank and reach the same storage. Peripheral registers and general-purpose RAM are private to each bank.

A pointer read with its top bit set goes to program memory instead. The decoder outputs the word address, wrapped into the implemented program size, and raises a stall for one cycle to cover the extra fetch. A pointer write with the top bit set is dropped. A read from a location with no storage behind it raises `rd_zero` so that the data path returns zero. The decoder holds no register contents itself. Its only state is one flag that times the program-memory stall.

Top module: `bdm_addr_decode`

## Requirements
- R1: With `use_ptr`=0 the data address is {`bank_num`,`dir_off`}. With `use_ptr`=1 and `ptr_val[15]`=0 it is `ptr_val[11:0]`, with bank = bits 11:7 and offset = bits 6:0. If `ptr_val[14:12]` is nonzero, the access has no storage behind it.
- R2: Offsets 0x00 to 0x0B select the core registers in every bank (`sel_core`=1) with `local_idx` = offset. The bank does not change the index.
- R3: Offsets 0x0C to 0x1F select peripheral registers (`sel_periph`=1) with `local_idx` = bank*20 + (offset - 0x0C).
- R4: Offsets 0x20 to 0x6F select general-purpose RAM (`sel_gpr`=1) with `local_idx` = bank*80 + (offset - 0x20), but only in banks below `GPR_BANKS` (default 4). In higher banks this window has no storage.
- R5: Offsets 0x70 to 0x7F select the common RAM in every bank (`sel_shared`=1) with `local_idx` = offset - 0x70.
- R6: A read of a location with no storage sets `rd_zero`=1, with every select low and `local_idx`=0. A write there sets nothing.
- R7: A pointer read with `ptr_val[15]`=1 sets `sel_prog`=1 and `prog_addr` = `ptr_val[14:0]` modulo `PM_WORDS` (default 2048). In the same cycle the data selects are low.
- R8: `stall` is 1 in the first cycle of a program-memory read and 0 in the second cycle. If the read is held longer, the following cycle starts a new access, so `stall` runs 1,0,1,0.
- R9: A pointer write with `ptr_val[15]`=1 is ignored: every select, `rd_zero` and `stall` stay 0. A cycle with both strobes high counts as a write.
- R10: With neither strobe high all outputs are 0. At no time is more than one select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| use_ptr | input | 1 | 1: pointer form, 0: bank plus direct offset |
| bank_num | input | 5 | Bank number for direct access |
| dir_off | input | 7 | Direct offset within the bank |
| ptr_val | input | 16 | Indirect pointer |
| sel_core | output | 1 | Core register region selected |
| sel_periph | output | 1 | Peripheral register region selected |
| sel_gpr | output | 1 | General-purpose RAM selected |
| sel_shared | output | 1 | Common RAM selected |
| sel_prog | output | 1 | Program-memory read selected |
| local_idx | output | 12 | Index within the selected data region |
| prog_addr | output | PM_AW (11) | Wrapped program-memory word address |
| rd_zero | output | 1 | Read hits no storage; data forced to zero |
| stall | output | 1 | Extra cycle for a program-memory read |

## Verification
Selects, `local_idx`, `prog_addr` and `rd_zero` are combinational. They are due in the same cycle as the stimulus. The bench drives its inputs on the falling edge and samples one nanosecond later, before the next rising edge. `stall` depends on one flag that updates on the rising edge. It is checked in the first cycle of a program-memory read, and again after each following falling edge while the read is held. Every program-memory scenario first spends one idle cycle so that the flag starts clear.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
    localparam int BANK_W   = 5;
    localparam int OFF_W    = 7;
    localparam int PTR_W    = 16;
    localparam int DADDR_W  = BANK_W + OFF_W;
    localparam int CORE_N   = 12;
    localparam int PERIPH_N = 20;
    localparam int SHARED_N = 16;
    localparam int GPR_N    = (2 ** OFF_W) - CORE_N - PERIPH_N - SHARED_N;
    localparam int NBANKS   = 2 ** BANK_W;
    localparam int IDX_W    = $clog2(NBANKS * GPR_N);

    localparam logic [OFF_W-1:0] PERIPH_BASE = OFF_W'(CORE_N);
    localparam logic [OFF_W-1:0] GPR_BASE    = OFF_W'(CORE_N + PERIPH_N);
    localparam logic [OFF_W-1:0] SHARED_BASE = OFF_W'(CORE_N + PERIPH_N + GPR_N);

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_CORE,
        RGN_PERIPH,
        RGN_GPR,
        RGN_SHARED
    } region_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [OFF_W-1:0]  off;
    } daddr_t;

    typedef struct packed {
        region_t          rgn;
        logic [IDX_W-1:0] idx;
    } hit_t;

    function automatic logic [IDX_W-1:0] bank_base(input logic [BANK_W-1:0] b,
                                                   input int per_bank);
        return IDX_W'(b) * IDX_W'(per_bank);
    endfunction
endpackage

// File: rtl/bdm_addr_form.sv
module bdm_addr_form
    import bdm_pkg::*;
#(
    parameter int PM_AW = 11
) (
    input  logic              use_ptr,
    input  logic [BANK_W-1:0] bank_num,
    input  logic [OFF_W-1:0]  dir_off,
    input  logic [PTR_W-1:0]  ptr_val,
    output daddr_t            daddr,
    output logic              space_ok,
    output logic              to_prog,
    output logic [PM_AW-1:0]  pm_addr
);
    localparam int HI_LSB = DADDR_W;
    localparam int HI_MSB = PTR_W - 2;

    always_comb begin
        if (use_ptr) begin
            daddr    = daddr_t'(ptr_val[DADDR_W-1:0]);
            to_prog  = ptr_val[PTR_W-1];
            space_ok = !ptr_val[PTR_W-1] && (ptr_val[HI_MSB:HI_LSB] == '0);
        end else begin
            daddr    = '{bank: bank_num, off: dir_off};
            to_prog  = 1'b0;
            space_ok = 1'b1;
        end
    end

    // Power-of-two program size: dropping upper bits is the wrap.
    assign pm_addr = ptr_val[PM_AW-1:0];
endmodule

// File: rtl/bdm_region_dec.sv
module bdm_region_dec
    import bdm_pkg::*;
#(
    parameter int GPR_BANKS = 4
) (
    input  daddr_t daddr,
    output hit_t   hit
);
    logic gpr_ok;

    generate
        if (GPR_BANKS >= NBANKS) begin : g_all_gpr
            assign gpr_ok = 1'b1;
        end else begin : g_some_gpr
            assign gpr_ok = (32'(daddr.bank) < GPR_BANKS);
        end
    endgenerate

    always_comb begin
        hit = '{rgn: RGN_NONE, idx: '0};
        if (daddr.off < PERIPH_BASE) begin
            hit.rgn = RGN_CORE;
            hit.idx = IDX_W'(daddr.off);
        end else if (daddr.off < GPR_BASE) begin
            hit.rgn = RGN_PERIPH;
            hit.idx = bank_base(daddr.bank, PERIPH_N)
                    + IDX_W'(daddr.off - PERIPH_BASE);
        end else if (daddr.off < SHARED_BASE) begin
            if (gpr_ok) begin
                hit.rgn = RGN_GPR;
                hit.idx = bank_base(daddr.bank, GPR_N)
                        + IDX_W'(daddr.off - GPR_BASE);
            end
        end else begin
            hit.rgn = RGN_SHARED;
            hit.idx = IDX_W'(daddr.off - SHARED_BASE);
        end
    end
endmodule

// File: rtl/bdm_stall_ctl.sv
module bdm_stall_ctl (
    input  logic clk,
    input  logic rst,
    input  logic pm_rd,
    output logic stall
);
    logic fetch_done;

    always_ff @(posedge clk) begin
        if (rst) fetch_done <= 1'b0;
        else     fetch_done <= pm_rd && !fetch_done;
    end

    assign stall = pm_rd && !fetch_done;

    AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall); // R8
endmodule

// File: rtl/bdm_addr_decode.sv
module bdm_addr_decode
    import bdm_pkg::*;
#(
    parameter  int PM_WORDS  = 2048,
    parameter  int GPR_BANKS = 4,
    localparam int PM_AW     = $clog2(PM_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_rd,
    input  logic             acc_wr,
    input  logic             use_ptr,
    input  logic [4:0]       bank_num,
    input  logic [6:0]       dir_off,
    input  logic [15:0]      ptr_val,
    output logic             sel_core,
    output logic             sel_periph,
    output logic             sel_gpr,
    output logic             sel_shared,
    output logic             sel_prog,
    output logic [11:0]      local_idx,
    output logic [PM_AW-1:0] prog_addr,
    output logic             rd_zero,
    output logic             stall
);
    daddr_t           daddr;
    logic             space_ok;
    logic             to_prog;
    logic [PM_AW-1:0] pm_addr;
    hit_t             hit;
    logic             is_wr, is_rd, data_act, pm_rd;

    bdm_addr_form #(.PM_AW(PM_AW)) u_form (
        .use_ptr  (use_ptr),
        .bank_num (bank_num),
        .dir_off  (dir_off),
        .ptr_val  (ptr_val),
        .daddr    (daddr),
        .space_ok (space_ok),
        .to_prog  (to_prog),
        .pm_addr  (pm_addr)
    );

    bdm_region_dec #(.GPR_BANKS(GPR_BANKS)) u_dec (
        .daddr (daddr),
        .hit   (hit)
    );

    assign is_wr    = acc_wr;
    assign is_rd    = acc_rd && !acc_wr;
    assign pm_rd    = is_rd && to_prog;
    assign data_act = (is_rd || is_wr) && !to_prog && space_ok
                      && (hit.rgn != RGN_NONE);

    bdm_stall_ctl u_stall (
        .clk   (clk),
        .rst   (rst),
        .pm_rd (pm_rd),
        .stall (stall)
    );

    assign sel_core   = data_act && (hit.rgn == RGN_CORE);
    assign sel_periph = data_act && (hit.rgn == RGN_PERIPH);
    assign sel_gpr    = data_act && (hit.rgn == RGN_GPR);
    assign sel_shared = data_act && (hit.rgn == RGN_SHARED);
    assign sel_prog   = pm_rd;
    assign local_idx  = data_act ? 12'(hit.idx) : '0;
    assign prog_addr  = pm_rd ? pm_addr : '0;
    assign rd_zero    = is_rd && !to_prog && !data_act;

    logic [4:0] sels;
    assign sels = {sel_core, sel_periph, sel_gpr, sel_shared, sel_prog};

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sels)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(acc_rd || acc_wr) |-> (sels == '0) && !rd_zero && !stall); // R10
    AST_PM_WRITE_DROP: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && use_ptr && ptr_val[15]) |-> (sels == '0) && !stall && !rd_zero); // R9
    AST_ZERO_EXCL: assert property (@(posedge clk) disable iff (rst)
        rd_zero |-> (sels == '0) && (local_idx == '0)); // R6
    AST_STALL_PROG: assert property (@(posedge clk) disable iff (rst)
        stall |-> sel_prog); // R8
endmodule

// File: tb/bdm_addr_decode_tb.sv
module bdm_addr_decode_tb_top;
    localparam int PM_AW = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_rd = 1'b0, acc_wr = 1'b0, use_ptr = 1'b0;
    logic [4:0]  bank_num = '0;
    logic [6:0]  dir_off = '0;
    logic [15:0] ptr_val = '0;
    logic sel_core, sel_periph, sel_gpr, sel_shared, sel_prog, rd_zero, stall;
    logic [11:0] local_idx;
    logic [PM_AW-1:0] prog_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bdm_addr_decode dut_i (
        .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .use_ptr(use_ptr), .bank_num(bank_num), .dir_off(dir_off),
        .ptr_val(ptr_val), .sel_core(sel_core), .sel_periph(sel_periph),
        .sel_gpr(sel_gpr), .sel_shared(sel_shared), .sel_prog(sel_prog),
        .local_idx(local_idx), .prog_addr(prog_addr), .rd_zero(rd_zero),
        .stall(stall)
    );

    // Order: core, periph, gpr, shared, prog, idx, paddr, zero, stall
    task automatic expect_out(input string rq, input logic [4:0] sel,
                              input int idx, input int pa,
                              input logic z, input logic st);
        logic [29:0] act, exp;
        act = {sel_core, sel_periph, sel_gpr, sel_shared, sel_prog,
               local_idx, prog_addr, rd_zero, stall};
        exp = {sel, 12'(idx), 11'(pa), z, st};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic apply(input logic rd, input logic wr, input logic up,
                         input int bank, input int off, input int ptr);
        @(negedge clk);
        acc_rd = rd; acc_wr = wr; use_ptr = up;
        bank_num = 5'(bank); dir_off = 7'(off); ptr_val = 16'(ptr);
        #1;
    endtask

    task automatic t_reset;
        apply(0, 0, 0, 0, 0, 0);
        expect_out("R10 reset idle", 5'b00000, 0, 0, 0, 0);
        apply(0, 0, 1, 3, 5, 16'h8123);
        expect_out("R10 no strobe", 5'b00000, 0, 0, 0, 0);
    endtask

    task automatic t_core;
        apply(1, 0, 0, 7, 7'h05, 0);
        expect_out("R2 core bank7", 5'b10000, 5, 0, 0, 0);
        apply(0, 1, 0, 0, 7'h0B, 0);
        expect_out("R2 core last", 5'b10000, 11, 0, 0, 0);
    endtask

    task automatic t_periph;
        apply(1, 0, 0, 3, 7'h0C, 0);
        expect_out("R3 periph first", 5'b01000, 60, 0, 0, 0);
        apply(1, 0, 0, 31, 7'h1F, 0);
        expect_out("R3 periph last", 5'b01000, 639, 0, 0, 0);
    endtask

    task automatic t_gpr;
        apply(1, 0, 0, 2, 7'h20, 0);
        expect_out("R4 gpr first", 5'b00100, 160, 0, 0, 0);
        apply(0, 1, 0, 3, 7'h6F, 0);
        expect_out("R4 gpr last", 5'b00100, 319, 0, 0, 0);
        apply(1, 0, 0, 4, 7'h20, 0);
        expect_out("R4 R6 gpr absent bank", 5'b00000, 0, 0, 1, 0);
        apply(0, 1, 0, 4, 7'h30, 0);
        expect_out("R6 write no storage", 5'b00000, 0, 0, 0, 0);
    endtask

    task automatic t_shared;
        apply(1, 0, 0, 9, 7'h7F, 0);
        expect_out("R5 shared top", 5'b00010, 15, 0, 0, 0);
        apply(1, 0, 0, 0, 7'h70, 0);
        expect_out("R5 shared base", 5'b00010, 0, 0, 0, 0);
    endtask

    task automatic t_pointer;
        apply(1, 0, 1, 0, 0, 16'h0125);
        expect_out("R1 ptr gpr", 5'b00100, 165, 0, 0, 0);
        apply(1, 0, 1, 0, 0, 16'h0F8D);
        expect_out("R1 ptr periph", 5'b01000, 31 * 20 + 1, 0, 0, 0);
        apply(1, 0, 1, 0, 0, 16'h1005);
        expect_out("R1 R6 ptr high bits", 5'b00000, 0, 0, 1, 0);
        apply(1, 0, 0, 1, 7'h02, 16'h8000);
        expect_out("R1 direct ignores ptr", 5'b10000, 2, 0, 0, 0);
    endtask

    task automatic t_prog;
        apply(0, 0, 0, 0, 0, 0);
        apply(1, 0, 1, 0, 0, 16'h8ABC);
        expect_out("R7 R8 prog read", 5'b00001, 0, 16'h02BC, 0, 1);
        apply(0, 0, 0, 0, 0, 0);
        apply(1, 0, 1, 0, 0, 16'hFFFF);
        expect_out("R7 prog wrap", 5'b00001, 0, 16'h07FF, 0, 1);
    endtask

    task automatic t_hold;
        apply(0, 0, 0, 0, 0, 0);
        apply(1, 0, 1, 0, 0, 16'h8010);
        expect_out("R8 held c1", 5'b00001, 0, 16'h0010, 0, 1);
        @(negedge clk); #1;
        expect_out("R8 held c2", 5'b00001, 0, 16'h0010, 0, 0);
        @(negedge clk); #1;
        expect_out("R8 held c3", 5'b00001, 0, 16'h0010, 0, 1);
    endtask

    task automatic t_pm_write;
        apply(0, 0, 0, 0, 0, 0);
        apply(0, 1, 1, 0, 0, 16'h8010);
        expect_out("R9 prog write", 5'b00000, 0, 0, 0, 0);
        apply(1, 1, 1, 0, 0, 16'h8010);
        expect_out("R9 both strobes", 5'b00000, 0, 0, 0, 0);
        apply(0, 0, 0, 0, 0, 0);
        expect_out("R10 idle after", 5'b00000, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_core();
        t_periph();
        t_gpr();
        t_shared();
        t_pointer();
        t_prog();
        t_hold();
        t_pm_write();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule